// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block is a 16-bit up/down timer that drives one center-aligned PWM output. The counter climbs from zero to a modulo limit, then falls back to zero, and repeats. Each pass through the compare value toggles the output in a direction set by a two-bit polarity selector. With one polarity the high time sits around the counter peak. With the other polarity the high time sits around the counter trough.

The compare value is read as a signed number. Zero or any negative value gives a constant low output. A positive value at or above a nonzero modulo gives a constant high output. In both cases the match flag stays quiet. A sticky period flag marks each return of the counter to zero. A sticky match flag marks each valid compare hit. Each flag has its own clear strobe. The modulo and compare values come straight from input ports and take effect on the next clock edge.

Top module: `cpwm_channel`

## Requirements
- R1: After reset the counter runs 0,1,...,MOD while counting up (`cnt_down`=0). It then runs MOD-1,...,1,0 while counting down (`cnt_down`=1), and then continues 1 counting up.
- R2: `tof` becomes 1 in the cycle after the counter sits at 0 with `cnt_down`=1. It stays 1 until `tof_clr` is high at a clock edge. A set and a clear in the same cycle leave it at 1.
- R3: With `edge_sel`=01 or 11 and a normal compare value, `pwm_out` goes high in the cycle after an up-counting match. It goes low in the cycle after a down-counting match.
- R4: With `edge_sel`=10 and a normal compare value, `pwm_out` goes low in the cycle after an up-counting match. It goes high in the cycle after a down-counting match.
- R5: With `edge_sel`=00, `pwm_out` is low. `chf` still sets on a normal match.
- R6: If `cmp_val` is 0 or its bit 15 is 1, `pwm_out` is low from the next cycle onward in every mode, and `chf` never sets.
- R7: If `cmp_val` bit 15 is 0, `cmp_val` ≥ `mod_val` and `mod_val` ≠ 0, `pwm_out` is high from the next cycle onward when `edge_sel` ≠ 00, and `chf` never sets.
- R8: For any other compare value, `chf` becomes 1 in the cycle after each match, whether counting up or down. It stays 1 until `chf_clr` is high at a clock edge. A set and a clear in the same cycle leave it at 1.
- R9: While `rst_n` is low, `cnt`=0, `cnt_down`=0, `pwm_out`=0, `tof`=0 and `chf`=0.
- R10: With `mod_val`=0, the counter first falls to 0. It then holds at 0 counting up, and `tof` does not set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| mod_val | input | 16 | Modulo (peak count) |
| cmp_val | input | 16 | Compare value, signed |
| edge_sel | input | 2 | Output polarity select: 00 off, 10 high at trough, x1 high at peak |
| tof_clr | input | 1 | Clear strobe for `tof` |
| chf_clr | input | 1 | Clear strobe for `chf` |
| cnt | output | 16 | Current count |
| cnt_down | output | 1 | 1 while in the down-counting phase |
| pwm_out | output | 1 | Registered channel output |
| tof | output | 1 | Sticky period-end flag |
| chf | output | 1 | Sticky channel-match flag |

## Verification
The assertions treat `mod_val`, `cmp_val` and `edge_sel` as synchronous values that are sampled at each edge. They make no assumption that these inputs stay constant between edges. The bench changes them only away from clock edges. It also keeps `mod_val` below 0x8000, so the counter never reaches counts whose top bit is set. A change to the modulo or compare value is given at least one full period to settle before the output is judged.

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mod_val,
  input  logic [W-1:0] cmp_val,
  input  logic [1:0]   edge_sel,
  input  logic         tof_clr,
  input  logic         chf_clr,
  output logic [W-1:0] cnt,
  output logic         cnt_down,
  output logic         pwm_out,
  output logic         tof,
  output logic         chf
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic match, zero_duty, full_duty, hit, at_bottom;
  logic pwm_d;

  assign match     = (cnt == cmp_val);
  assign zero_duty = (cmp_val == ZERO) || cmp_val[W-1];
  assign full_duty = !cmp_val[W-1] && (cmp_val >= mod_val) && (mod_val != ZERO);
  assign hit       = match && !zero_duty && !full_duty;
  assign at_bottom = cnt_down && (cnt == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= ZERO;
      cnt_down <= 1'b0;
    end else if (cnt_down) begin
      if (cnt == ZERO) begin
        cnt_down <= 1'b0;
        cnt      <= (mod_val == ZERO) ? ZERO : ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end else if (cnt >= mod_val) begin
      if (cnt != ZERO) begin
        cnt      <= cnt - ONE;
        cnt_down <= 1'b1;
      end
    end else begin
      cnt <= cnt + ONE;
    end
  end

  always_comb begin
    pwm_d = pwm_out;
    if (edge_sel == 2'b00)  pwm_d = 1'b0;
    else if (zero_duty)     pwm_d = 1'b0;
    else if (full_duty)     pwm_d = 1'b1;
    else if (match)         pwm_d = edge_sel[0] ? !cnt_down : cnt_down;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_out <= 1'b0;
      tof     <= 1'b0;
      chf     <= 1'b0;
    end else begin
      pwm_out <= pwm_d;
      tof     <= at_bottom | (tof & ~tof_clr);
      chf     <= hit | (chf & ~chf_clr);
    end
  end

  assert_count_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_down && cnt < mod_val) |=> (!cnt_down && cnt == $past(cnt) + ONE));

  assert_turn_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_down && cnt == mod_val && mod_val != ZERO) |=> (cnt_down && cnt == $past(mod_val) - ONE));

  assert_tof_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_down && cnt == ZERO) |=> tof);

  assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |=> !pwm_out);

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_val == ZERO || cmp_val[W-1]) |=> !pwm_out);

  assert_corner_no_chf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!chf && (cmp_val == ZERO || cmp_val[W-1] || (cmp_val >= mod_val && mod_val != ZERO))) |=> !chf);

  assert_chf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chf && !chf_clr) |=> chf);

  assert_mod_zero_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_val == ZERO && cnt == ZERO) |=> (cnt == ZERO));

endmodule

// File: tb/tb_cpwm_channel.sv
module tb_cpwm_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mod_val, cmp_val;
  logic [1:0]  edge_sel;
  logic        tof_clr, chf_clr;
  logic [15:0] cnt;
  logic        cnt_down, pwm_out, tof, chf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cpwm_channel dut (
    .clk(clk), .rst_n(rst_n), .mod_val(mod_val), .cmp_val(cmp_val),
    .edge_sel(edge_sel), .tof_clr(tof_clr), .chf_clr(chf_clr),
    .cnt(cnt), .cnt_down(cnt_down), .pwm_out(pwm_out), .tof(tof), .chf(chf)
  );

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_for(logic [15:0] v, logic d);
    for (int i = 0; i < 200; i++) begin
      if (cnt == v && cnt_down == d) return;
      step();
    end
    check("wait_for timeout", 32'd1, 32'd0);
  endtask

  task automatic clear_chf();
    chf_clr = 1'b1; step(); chf_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mod_val = 16'd8; cmp_val = 16'd3; edge_sel = 2'b00;
    tof_clr = 1'b0; chf_clr = 1'b0;
    step(); step();
    check("R9 cnt", 32'(cnt), 32'd0);
    check("R9 dir", 32'(cnt_down), 32'd0);
    check("R9 pwm", 32'(pwm_out), 32'd0);
    check("R9 flags", {30'd0, tof, chf}, 32'd0);
  endtask

  task automatic t_count();
    rst_n = 1'b1;
    for (int k = 1; k <= 17; k++) begin
      int e;
      step();
      e = (k <= 8) ? k : ((k <= 16) ? 16 - k : k - 16);
      check($sformatf("R1 cnt step %0d", k), 32'(cnt), 32'(e));
      check($sformatf("R1 dir step %0d", k), 32'(cnt_down), (k >= 9 && k <= 16) ? 32'd1 : 32'd0);
      if (k == 16) check("R2 tof before", 32'(tof), 32'd0);
      if (k == 17) check("R2 tof set", 32'(tof), 32'd1);
    end
    step(); step();
    check("R2 tof sticky", 32'(tof), 32'd1);
    tof_clr = 1'b1; step(); tof_clr = 1'b0;
    check("R2 tof cleared", 32'(tof), 32'd0);
    wait_for(16'd0, 1'b1);
    tof_clr = 1'b1; step(); tof_clr = 1'b0;
    check("R2 tof set wins", 32'(tof), 32'd1);
  endtask

  task automatic t_peak_high();
    edge_sel = 2'b01; cmp_val = 16'd5;
    clear_chf();
    wait_for(16'd5, 1'b0);
    step();
    check("R3 up match high", 32'(pwm_out), 32'd1);
    check("R8 chf up match", 32'(chf), 32'd1);
    wait_for(16'd5, 1'b1);
    step();
    check("R3 down match low", 32'(pwm_out), 32'd0);
    check("R8 chf sticky", 32'(chf), 32'd1);
    clear_chf();
    check("R8 chf cleared", 32'(chf), 32'd0);
    wait_for(16'd5, 1'b0);
    chf_clr = 1'b1; step(); chf_clr = 1'b0;
    check("R8 chf set wins", 32'(chf), 32'd1);
    edge_sel = 2'b11;
    wait_for(16'd5, 1'b1);
    step();
    check("R3 mode 11 down low", 32'(pwm_out), 32'd0);
    wait_for(16'd5, 1'b0);
    step();
    check("R3 mode 11 up high", 32'(pwm_out), 32'd1);
  endtask

  task automatic t_trough_high();
    edge_sel = 2'b10; cmp_val = 16'd5;
    wait_for(16'd5, 1'b0);
    step();
    check("R4 up match low", 32'(pwm_out), 32'd0);
    wait_for(16'd5, 1'b1);
    step();
    check("R4 down match high", 32'(pwm_out), 32'd1);
  endtask

  task automatic t_off();
    edge_sel = 2'b00; cmp_val = 16'd5;
    step();
    clear_chf();
    wait_for(16'd5, 1'b1);
    step();
    check("R5 off low", 32'(pwm_out), 32'd0);
    check("R5 chf still set", 32'(chf), 32'd1);
  endtask

  task automatic t_const(string req, logic [15:0] c, logic [1:0] es, logic lvl);
    int bad = 0;
    cmp_val = c; edge_sel = es;
    step();
    clear_chf();
    for (int i = 0; i < 18; i++) begin
      step();
      if (pwm_out !== lvl) bad++;
    end
    check({req, " level"}, 32'(bad), 32'd0);
    check({req, " no chf"}, 32'(chf), 32'd0);
  endtask

  task automatic t_mod_zero();
    edge_sel = 2'b10; cmp_val = 16'd3; mod_val = 16'd0;
    for (int i = 0; i < 20; i++) step();
    tof_clr = 1'b1; step(); tof_clr = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      check("R10 cnt held", {15'd0, cnt_down, cnt}, 32'd0);
    end
    check("R10 no tof", 32'(tof), 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count();
    t_peak_high();
    t_trough_high();
    t_off();
    t_const("R6 zero cmp", 16'h0000, 2'b10, 1'b0);
    t_const("R6 negative cmp", 16'h8003, 2'b01, 1'b0);
    t_const("R7 cmp eq mod", 16'd8, 2'b01, 1'b1);
    t_const("R7 cmp above mod", 16'd20, 2'b10, 1'b1);
    t_mod_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule